// File: doc/BRIEF.md
# 64-bit Compare Timer with Periodic Re-arm

This block is a free-running 64-bit up-counter with a 64-bit comparator. Software reaches it over a simple register port with 32-bit words: a valid strobe, a write flag, a byte address and write data. Read data comes back one cycle later. Every 64-bit quantity is held as a low word and a high word. A control word lets software start and stop the counter, enable the comparator, enable the interrupt and choose periodic operation.

When the comparator is enabled and the counter reaches or passes the comparator value, a sticky event flag is set. Software clears the flag by writing a one to it. In periodic mode, each event adds a programmed period to the comparator, so events repeat at that spacing. In single-shot mode, an event disarms the comparator. It fires again only after a comparator word is written or the comparator enable goes from 0 to 1. The interrupt line is the flag gated by the interrupt enable.

Top module: `ctm_top`

## Requirements
- R1: After reset, every register reads as zero and `irq` is low. A read of an unused offset, such as 0x1C, returns zero.
- R2: The counter goes up by one each clock while control bit 0 (timer enable) is set. It holds its value while that bit is clear.
- R3: Writes to the counter low word (0x00) and high word (0x04) load that word only while the timer is disabled. While the timer runs, such writes are ignored and counting continues.
- R4: When the counter low word steps from 0xFFFFFFFF, it becomes zero and the high word goes up by one in the same clock.
- R5: With control bit 1 (compare enable) set and the comparator armed, the event occurs when the counter is unsigned greater than or equal to the comparator (low word 0x10, high word 0x14). The event sets bit 0 of the status register (0x0C) on the next clock. A comparator that is larger only in its high word causes no event.
- R6: While compare enable is clear, no event occurs and the status flag is not set, even when the counter is at or past the comparator.
- R7: The status flag is sticky. Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R8: When control bit 3 (auto-increment) is clear, an event disarms the comparator. No later event occurs until a comparator word is written or compare enable is written from 0 to 1.
- R9: When auto-increment is set, each event adds the 32-bit period register (0x18) to the 64-bit comparator, and the comparator stays armed.
- R10: `irq` is high exactly when the status flag and control bit 2 (interrupt enable) are both set, and it changes in the same cycle as the status flag.
- R11: A read returns data on `bus_rdata` one clock after it is issued. The control (0x08), comparator and period registers read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the read |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each access lasts a single cycle and that the address and write flag are stable while valid is high. They also assume that reset is held for at least one edge before any access. The bench drives every access for exactly one clock, starting at a falling edge, with valid low between accesses. It leaves idle cycles after any write that can cause an event before it reads the status. When the counter runs, it is started and stopped by control writes a known number of cycles apart, so the expected count and comparator values follow directly from R2 and R9.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int WORD_W = 32;

  // byte offsets of the word registers
  localparam logic [7:0] OFF_CNT_LO = 8'h00;
  localparam logic [7:0] OFF_CNT_HI = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam logic [7:0] OFF_STAT   = 8'h0C;
  localparam logic [7:0] OFF_CMP_LO = 8'h10;
  localparam logic [7:0] OFF_CMP_HI = 8'h14;
  localparam logic [7:0] OFF_PERIOD = 8'h18;

  // control bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_CMP  = 1;
  localparam int CB_IRQ  = 2;
  localparam int CB_AUTO = 3;
  localparam int CTRL_W  = 4;
endpackage

// File: rtl/ctm_counter.sv
module ctm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         ld_lo_i,
  input  logic         ld_hi_i,
  input  logic [W-1:0] wdata_i,
  output logic [2*W-1:0] cnt_o
);
  localparam int CW = 2 * W;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + CW'(1);
    end else if (ld_lo_i) begin
      cnt_q[W-1:0] <= wdata_i;
    end else if (ld_hi_i) begin
      cnt_q[CW-1:W] <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !ld_lo_i && !ld_hi_i) |=> cnt_o == $past(cnt_o)); // R2
  AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (en_i && (ld_lo_i || ld_hi_i)) |=> cnt_o == $past(cnt_o) + CW'(1)); // R3
  AST_CARRY: assert property (@(posedge clk) disable iff (rst)
    (en_i && cnt_o[W-1:0] == '1) |=>
      (cnt_o[W-1:0] == '0 && cnt_o[CW-1:W] == $past(cnt_o[CW-1:W]) + W'(1))); // R4
endmodule

// File: rtl/ctm_compare.sv
module ctm_compare #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*W-1:0] cnt_i,
  input  logic           cmp_en_i,
  input  logic           auto_en_i,
  input  logic           arm_i,
  input  logic           wr_lo_i,
  input  logic           wr_hi_i,
  input  logic           wr_per_i,
  input  logic [W-1:0]   wdata_i,
  output logic [2*W-1:0] cmp_o,
  output logic [W-1:0]   per_o,
  output logic           evt_o
);
  localparam int CW = 2 * W;

  logic [CW-1:0] cmp_q;
  logic [W-1:0]  per_q;
  logic          armed_q;
  logic          evt;
  logic          rearm;

  assign rearm = wr_lo_i | wr_hi_i | arm_i;
  assign evt   = cmp_en_i & armed_q & (cnt_i >= cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q   <= '0;
      per_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_per_i) per_q <= wdata_i;
      if (wr_lo_i) begin
        cmp_q[W-1:0] <= wdata_i;
      end else if (wr_hi_i) begin
        cmp_q[CW-1:W] <= wdata_i;
      end else if (evt && auto_en_i) begin
        cmp_q <= cmp_q + {{W{1'b0}}, per_q};
      end
      if (rearm) begin
        armed_q <= 1'b1;
      end else if (evt && !auto_en_i) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign cmp_o = cmp_q;
  assign per_o = per_q;
  assign evt_o = evt;

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (evt_o && !auto_en_i && !rearm) |=> !evt_o); // R8
  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (rst)
    (evt_o && auto_en_i && !wr_lo_i && !wr_hi_i) |=>
      cmp_o == $past(cmp_o) + {{W{1'b0}}, $past(per_o)}); // R9
  AST_NO_EVT_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !cmp_en_i |-> !evt_o); // R6
endmodule

// File: rtl/ctm_top.sv
module ctm_top #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = ctm_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import ctm_pkg::*;

  localparam int CW = 2 * DATA_W;

  logic wr, rd;
  logic sel_clo, sel_chi, sel_ctl, sel_sta, sel_mlo, sel_mhi, sel_per;

  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;

  assign sel_clo = bus_addr == ADDR_W'(OFF_CNT_LO);
  assign sel_chi = bus_addr == ADDR_W'(OFF_CNT_HI);
  assign sel_ctl = bus_addr == ADDR_W'(OFF_CTRL);
  assign sel_sta = bus_addr == ADDR_W'(OFF_STAT);
  assign sel_mlo = bus_addr == ADDR_W'(OFF_CMP_LO);
  assign sel_mhi = bus_addr == ADDR_W'(OFF_CMP_HI);
  assign sel_per = bus_addr == ADDR_W'(OFF_PERIOD);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              stat_q, stat_d;
  logic              arm;
  logic              evt;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     cmp;
  logic [DATA_W-1:0] per;

  assign ctrl_d = (wr && sel_ctl) ? bus_wdata[CTRL_W-1:0] : ctrl_q;
  assign arm    = wr & sel_ctl & bus_wdata[CB_CMP] & ~ctrl_q[CB_CMP];
  assign stat_d = evt ? 1'b1 : ((wr && sel_sta && bus_wdata[0]) ? 1'b0 : stat_q);

  ctm_counter #(.W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .en_i    (ctrl_q[CB_RUN]),
    .ld_lo_i (wr & sel_clo),
    .ld_hi_i (wr & sel_chi),
    .wdata_i (bus_wdata),
    .cnt_o   (cnt)
  );

  ctm_compare #(.W(DATA_W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .cnt_i     (cnt),
    .cmp_en_i  (ctrl_q[CB_CMP]),
    .auto_en_i (ctrl_q[CB_AUTO]),
    .arm_i     (arm),
    .wr_lo_i   (wr & sel_mlo),
    .wr_hi_i   (wr & sel_mhi),
    .wr_per_i  (wr & sel_per),
    .wdata_i   (bus_wdata),
    .cmp_o     (cmp),
    .per_o     (per),
    .evt_o     (evt)
  );

  logic [DATA_W-1:0] rmux;

  always_comb begin
    rmux = '0;
    if (sel_clo) rmux = cnt[DATA_W-1:0];
    if (sel_chi) rmux = cnt[CW-1:DATA_W];
    if (sel_ctl) rmux = DATA_W'(ctrl_q);
    if (sel_sta) rmux = DATA_W'(stat_q);
    if (sel_mlo) rmux = cmp[DATA_W-1:0];
    if (sel_mhi) rmux = cmp[CW-1:DATA_W];
    if (sel_per) rmux = per;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      stat_q    <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      irq    <= stat_d & ctrl_d[CB_IRQ];
      if (rd) bus_rdata <= rmux;
    end
  end

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    evt |=> stat_q); // R5
  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CB_CMP] && !stat_q) |=> !stat_q); // R6
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr && sel_sta && bus_wdata[0] && !evt) |=> !stat_q); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stat_q && !(wr && sel_sta && bus_wdata[0])) |=> stat_q); // R7

  always_ff @(posedge clk) begin
    if (!rst) begin
      AST_IRQ_GATE: assert (irq == (stat_q && ctrl_q[CB_IRQ])); // R10
    end
  end
endmodule

// File: tb/tb_ctm_top.sv
module tb_ctm_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctm_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: a read captured at a rising edge is compared at the next falling edge
  always @(posedge clk) rd_seen <= bus_valid && !bus_write;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s: read actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [DW-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a[AW-1:0];
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R11 read latency
    chk_irq(1'b0, "R1");
    rd(8'h08, 32'h0, "R1 ctrl");
    rd(8'h00, 32'h0, "R1 cnt lo");
    rd(8'h04, 32'h0, "R1 cnt hi");
    rd(8'h0C, 32'h0, "R1 status");
    rd(8'h10, 32'h0, "R1 cmp lo");
    rd(8'h18, 32'h0, "R1 period");
    rd(8'h1C, 32'h0, "R1 unused");

    // R2 hold while disabled
    idle(5);
    rd(8'h00, 32'h0, "R2 hold");
    // R2 run for 10 cycles: enable, 9 idle, disable
    wr(8'h08, 32'h1);
    idle(9);
    wr(8'h08, 32'h0);
    rd(8'h00, 32'd10, "R2 count");
    rd(8'h08, 32'h0, "R11 ctrl readback");

    // R3 load while stopped, ignored while running
    wr(8'h00, 32'd100);
    wr(8'h04, 32'd0);
    rd(8'h00, 32'd100, "R3 load");
    wr(8'h08, 32'h1);
    wr(8'h00, 32'h1234);
    wr(8'h08, 32'h0);
    rd(8'h00, 32'd102, "R3 ignored");

    // R4 carry: three steps from FFFFFFFE with high 5
    wr(8'h00, 32'hFFFF_FFFE);
    wr(8'h04, 32'd5);
    wr(8'h08, 32'h1);
    idle(2);
    wr(8'h08, 32'h0);
    rd(8'h00, 32'd1, "R4 low");
    rd(8'h04, 32'd6, "R4 high");

    // R6 compare disabled: counter 100 past comparator 50
    wr(8'h00, 32'd100);
    wr(8'h04, 32'd0);
    wr(8'h10, 32'd50);
    wr(8'h14, 32'd0);
    wr(8'h08, 32'h4);
    idle(3);
    rd(8'h0C, 32'h0, "R6 status");
    chk_irq(1'b0, "R6");

    // R5 comparator larger only in high word: no event
    wr(8'h14, 32'd1);
    wr(8'h08, 32'h6);
    idle(3);
    rd(8'h0C, 32'h0, "R5 high word larger");
    rd(8'h14, 32'd1, "R11 cmp hi readback");
    // R5 counter greater than comparator: event
    wr(8'h14, 32'd0);
    idle(2);
    rd(8'h0C, 32'h1, "R5 ge event");
    chk_irq(1'b1, "R10 on");

    // R10 gating by interrupt enable
    wr(8'h08, 32'h2);
    chk_irq(1'b0, "R10 gated");
    rd(8'h0C, 32'h1, "R7 sticky");
    wr(8'h08, 32'h6);
    chk_irq(1'b1, "R10 regated");

    // R7 write zero keeps, write one clears
    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h1, "R7 write zero");
    wr(8'h0C, 32'h1);
    chk_irq(1'b0, "R7 clear irq");
    idle(3);
    rd(8'h0C, 32'h0, "R8 no refire");

    // R8 rearm by comparator write
    wr(8'h10, 32'd50);
    idle(2);
    rd(8'h0C, 32'h1, "R8 rearm");
    wr(8'h0C, 32'h1);
    idle(2);
    rd(8'h0C, 32'h0, "R8 cleared");

    // R9 periodic: cnt 0, cmp 10, period 5, run 23 cycles
    // events when cnt is 10, 15, 20 -> cmp 25
    wr(8'h08, 32'h0);
    wr(8'h00, 32'd0);
    wr(8'h04, 32'd0);
    wr(8'h10, 32'd10);
    wr(8'h18, 32'd5);
    wr(8'h08, 32'hB);
    idle(22);
    wr(8'h08, 32'h0);
    rd(8'h00, 32'd23, "R9 count");
    rd(8'h10, 32'd25, "R9 cmp lo");
    rd(8'h14, 32'd0, "R9 cmp hi");
    rd(8'h18, 32'd5, "R11 period readback");
    rd(8'h0C, 32'h1, "R9 status");
    chk_irq(1'b0, "R10 disabled");

    idle(2);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R11: reads pending actual=%0d expected=0", exp_q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule